// File: doc/BRIEF.md
# DMA Channel Activation Controller

This block decides, for each of sixteen DMA channels, whether that channel may start bus transactions. Software turns channels on and off through two write-only 32-bit ports. One port sets channels running. The other asks channels to stop. Only the low sixteen data bits are used, one per channel, and a single write can act on any number of channels at once. A channel also stops when its task finishes, or when the active bit in its own control register is cleared.

A channel that is told to stop while it still has transactions open on the bus does not stop at once. It moves into a draining state and keeps reading as active. It launches no new transactions, and a stop requested by software stays flagged. Once the last open transaction closes, the controller clears the channel and the flag by itself. Software confirms the shutdown by polling the active-status vector. Requests that reach a channel that is not running are simply dropped; nothing is queued for later. Each channel counts its open transactions: a launch adds one and a completion takes one away.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous reset, `act_stat`, `dis_stat` and `issue` are all zero.
- R2: An enable write with data bit n = 1 makes channel n active in `act_stat` from the next cycle. Data bits that are 0, and data bits 31..16, have no effect. Several channels can be enabled by one write.
- R3: A disable write with data bit n = 1, sent to a running channel that has no open transactions, clears channel n in `act_stat` on the next cycle. A disable write to an idle channel has no effect.
- R4: A stop request to a running channel whose open count after that cycle is non-zero leaves the channel active. If the stop came from a disable write, `dis_stat` bit n is also set. Both bits clear in the cycle after the completion that brings the count to zero.
- R5: `issue[n]` equals `req[n]` only while channel n is running. Requests to an idle channel are dropped and are not replayed after a later enable.
- R6: While channel n is draining, `issue[n]` stays 0 whatever `req[n]` does.
- R7: If enable and disable are both written for the same channel in one cycle, the disable wins. An idle channel stays idle, and a running channel begins shutdown.
- R8: A `task_done[n]` pulse on a running channel starts shutdown exactly as a disable does, but leaves `dis_stat[n]` at 0.
- R9: A 1-to-0 change of `ctl_act[n]` while channel n is running starts shutdown, with `dis_stat[n]` left at 0.
- R10: Each channel tracks up to 2^CNT_W-1 open transactions. At that count `issue[n]` is held at 0, and a `txn_done[n]` pulse at a count of zero is ignored.
- R11: An enable write to a draining channel is ignored. The channel still goes idle once its last transaction closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Strobe for a write to the enable port |
| en_wdata | input | 32 | Enable data; bit n = 1 starts channel n, bits 31..16 are reserved |
| dis_wr | input | 1 | Strobe for a write to the disable port |
| dis_wdata | input | 32 | Disable data; bit n = 1 stops channel n, bits 31..16 are reserved |
| ctl_act | input | 16 | Active bit from each channel's control register |
| req | input | 16 | Transaction request per channel |
| txn_done | input | 16 | One-cycle pulse: one bus transaction of channel n closed |
| task_done | input | 16 | One-cycle pulse: channel n finished its task |
| issue | output | 16 | Request accepted and launched on the bus this cycle |
| act_stat | output | 16 | Bit n high while channel n is running or draining |
| dis_stat | output | 16 | Bit n high while a software disable of channel n waits for its transactions to close |

## Verification
A table drives mixed sequences through the block. These include several channels enabled by one write, a disable that lands on a channel with an open transaction, a disable that lands on a channel with none, and enable and disable written together. They also include a task-done pulse with two transactions still open, and a disable of all sixteen channels in the same cycle as sixteen new launches. Together these separate an immediate stop from a drained stop, and a software stop (which raises `dis_stat`) from a hardware stop (which does not). Directed runs then cover the rest:
- filling one channel's counter to its limit, which shows that launches stop there and that draining lasts exactly as many completions as were counted;
- a falling control-register active bit;
- a reset applied while channels are running.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    localparam int NCH_DEF   = 16;
    localparam int REG_W_DEF = 32;
    localparam int CNT_W_DEF = 4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_st_e;

    typedef struct packed {
        ch_st_e st;
        logic   dis_pend;
        logic   ctl_q;
    } slot_reg_t;

    localparam slot_reg_t SLOT_RST = '{st: CH_IDLE, dis_pend: 1'b0, ctl_q: 1'b0};

    function automatic logic st_live(input ch_st_e s);
        return (s == CH_RUN) || (s == CH_DRAIN);
    endfunction

endpackage

// File: rtl/dchan_wr_decode.sv
module dchan_wr_decode #(
    parameter int NCH   = dchan_pkg::NCH_DEF,
    parameter int REG_W = dchan_pkg::REG_W_DEF
) (
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [NCH-1:0]   bits
);
    // Reserved upper bits are dropped here.
    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:NCH];

    always_comb begin
        bits = wr ? wdata[NCH-1:0] : '0;
    end
endmodule

// File: rtl/dchan_txn_ctr.sv
module dchan_txn_ctr #(
    parameter int CNT_W = dchan_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             full,
    output logic             zero
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic dec_ok;

    assign zero   = (cnt == '0);
    assign full   = (cnt == MAXV);
    assign dec_ok = dec && !zero;

    always_comb begin
        unique case ({inc, dec_ok})
            2'b10:   cnt_nxt = cnt + ONE;
            2'b01:   cnt_nxt = cnt - ONE;
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        inc |-> !full) else $error("counter increment at limit"); // R10

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !dec) |=> $stable(cnt)) else $error("counter moved without cause"); // R10
endmodule

// File: rtl/dchan_slot.sv
module dchan_slot
    import dchan_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en_set,
    input  logic dis_set,
    input  logic ctl_act,
    input  logic req,
    input  logic txn_done,
    input  logic task_done,
    output logic issue,
    output logic live,
    output logic dis_pend
);
    slot_reg_t        r_q, r_d;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             full, zero;
    logic             running, ctl_fall, stop_req, empty_nxt;

    assign running   = (r_q.st == CH_RUN);
    assign ctl_fall  = r_q.ctl_q && !ctl_act;
    assign stop_req  = dis_set || task_done || ctl_fall;
    assign issue     = req && running && !full;
    assign empty_nxt = (cnt_nxt == '0);

    dchan_txn_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .inc     (issue),
        .dec     (txn_done),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .full    (full),
        .zero    (zero)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ctl_q = ctl_act;
        unique case (r_q.st)
            CH_IDLE: begin
                r_d.dis_pend = 1'b0;
                if (en_set && !dis_set) r_d.st = CH_RUN;
            end
            CH_RUN: begin
                if (stop_req) begin
                    if (empty_nxt) begin
                        r_d.st       = CH_IDLE;
                        r_d.dis_pend = 1'b0;
                    end else begin
                        r_d.st       = CH_DRAIN;
                        r_d.dis_pend = dis_set;
                    end
                end
            end
            CH_DRAIN: begin
                if (empty_nxt) begin
                    r_d.st       = CH_IDLE;
                    r_d.dis_pend = 1'b0;
                end else begin
                    r_d.dis_pend = r_q.dis_pend || dis_set;
                end
            end
            default: begin
                r_d.st       = CH_IDLE;
                r_d.dis_pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= SLOT_RST;
        else     r_q <= r_d;
    end

    assign live     = st_live(r_q.st);
    assign dis_pend = r_q.dis_pend;

    AST_EN_STARTS: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_IDLE && en_set && !dis_set) |=> live) else $error("enable did not start channel"); // R2

    AST_IDLE_DIS_NOP: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_IDLE && dis_set) |=> !live) else $error("disable woke idle channel"); // R3

    AST_DRAIN_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_DRAIN) |-> !zero) else $error("draining with nothing open"); // R4

    AST_FLAG_IN_DRAIN: assert property (@(posedge clk) disable iff (rst)
        dis_pend |-> (r_q.st == CH_DRAIN)) else $error("disable flag outside drain"); // R4

    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !live |-> !issue) else $error("issue while idle"); // R5

    AST_NO_ISSUE_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_DRAIN) |-> !issue) else $error("issue while draining"); // R6

    AST_DIS_WINS: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_IDLE && en_set && dis_set) |=> !live) else $error("enable beat disable"); // R7

    AST_TASK_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (running && task_done && !dis_set) |=> !dis_pend) else $error("task end raised disable flag"); // R8

    AST_CTL_FALL_STOPS: assert property (@(posedge clk) disable iff (rst)
        (running && ctl_fall) |=> (r_q.st != CH_RUN)) else $error("control bit fall ignored"); // R9

    AST_DRAIN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_DRAIN) |=> (r_q.st != CH_RUN)) else $error("drain returned to run"); // R11
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dchan_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int REG_W = REG_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             dis_wr,
    input  logic [REG_W-1:0] dis_wdata,
    input  logic [NCH-1:0]   ctl_act,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   txn_done,
    input  logic [NCH-1:0]   task_done,
    output logic [NCH-1:0]   issue,
    output logic [NCH-1:0]   act_stat,
    output logic [NCH-1:0]   dis_stat
);
    logic [NCH-1:0] en_bits, dis_bits;

    dchan_wr_decode #(.NCH(NCH), .REG_W(REG_W)) u_en_dec (
        .wr    (en_wr),
        .wdata (en_wdata),
        .bits  (en_bits)
    );

    dchan_wr_decode #(.NCH(NCH), .REG_W(REG_W)) u_dis_dec (
        .wr    (dis_wr),
        .wdata (dis_wdata),
        .bits  (dis_bits)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dchan_slot #(.CNT_W(CNT_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .en_set    (en_bits[g]),
            .dis_set   (dis_bits[g]),
            .ctl_act   (ctl_act[g]),
            .req       (req[g]),
            .txn_done  (txn_done[g]),
            .task_done (task_done[g]),
            .issue     (issue[g]),
            .live      (act_stat[g]),
            .dis_pend  (dis_stat[g])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (act_stat == '0 && dis_stat == '0)) else $error("reset left state"); // R1

    AST_FLAG_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (dis_stat & ~act_stat) == '0) else $error("flag on inactive channel"); // R4
endmodule

// File: tb/sim_dma_chan_ctl.sv
module sim_dma_chan_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_wr = 1'b0, dis_wr = 1'b0;
    logic [31:0] en_wdata = '0, dis_wdata = '0;
    logic [15:0] ctl_act = 16'hFFFF, req = '0, txn_done = '0, task_done = '0;
    logic [15:0] issue, act_stat, dis_stat;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_chan_ctl u0 (
        .clk(clk), .rst(rst),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .dis_wr(dis_wr), .dis_wdata(dis_wdata),
        .ctl_act(ctl_act), .req(req), .txn_done(txn_done), .task_done(task_done),
        .issue(issue), .act_stat(act_stat), .dis_stat(dis_stat)
    );

    typedef struct packed {
        logic        ew;
        logic [31:0] ed;
        logic        dw;
        logic [31:0] dd;
        logic [15:0] rq;
        logic [15:0] dn;
        logic [15:0] tk;
        logic [15:0] x_iss;
        logic [15:0] x_act;
        logic [15:0] x_dis;
    } vec_t;

    // inputs; expected issue in the same cycle; expected act/dis after the edge
    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'h0000_0005, 1'b0, 32'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0005, 16'h0000}, // R2 multi
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'h000F, 16'h0000, 16'h0000, 16'h0005, 16'h0005, 16'h0000}, // R5
        '{1'b0, 32'h0,         1'b1, 32'h1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0005, 16'h0001}, // R4
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'h0005, 16'h0000, 16'h0000, 16'h0004, 16'h0005, 16'h0001}, // R6
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0004, 16'h0000}, // R4 close
        '{1'b1, 32'h0000_0002, 1'b1, 32'h2, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0000}, // R7
        '{1'b0, 32'h0,         1'b1, 32'h8, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0000}, // R3 idle
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'h0000, 16'h0000, 16'h0004, 16'h0000, 16'h0004, 16'h0000}, // R8
        '{1'b1, 32'h0000_0004, 1'b0, 32'h0, 16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'h0004, 16'h0000}, // R11
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R11 close
        '{1'b1, 32'hFFFF_0010, 1'b0, 32'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0010, 16'h0000}, // R2 upper
        '{1'b0, 32'h0,         1'b1, 32'h10,16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R3
        '{1'b1, 32'h0000_FFFF, 1'b0, 32'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000}, // R2 all
        '{1'b0, 32'h0,         1'b1, 32'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R4 all
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R6 R4
        '{1'b0, 32'h0,         1'b0, 32'h0, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0000}  // R5 R10
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        en_wr = 1'b0; en_wdata = '0; dis_wr = 1'b0; dis_wdata = '0;
        req = '0; txn_done = '0; task_done = '0;
    endtask

    // drive at negedge, settle, step one edge, land on the next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 act", act_stat, 16'h0);
        chk("R1 dis", dis_stat, 16'h0);
        chk("R1 issue", issue, 16'h0);

        for (int i = 0; i < NV; i++) begin
            en_wr = TBL[i].ew; en_wdata = TBL[i].ed;
            dis_wr = TBL[i].dw; dis_wdata = TBL[i].dd;
            req = TBL[i].rq; txn_done = TBL[i].dn; task_done = TBL[i].tk;
            #1;
            chk($sformatf("vec%0d issue R5", i), issue, TBL[i].x_iss);
            step();
            idle_in();
            chk($sformatf("vec%0d act R2", i), act_stat, TBL[i].x_act);
            chk($sformatf("vec%0d dis R4", i), dis_stat, TBL[i].x_dis);
        end

        // R10: saturate channel 5 at 15 open transactions
        en_wr = 1'b1; en_wdata = 32'h20;
        step();
        idle_in();
        for (int k = 0; k < 15; k++) begin
            req = 16'h0020;
            #1;
            chk("R10 issue below limit", issue, 16'h0020);
            step();
        end
        req = 16'h0020;
        #1;
        chk("R10 issue at limit", issue, 16'h0000);
        step();
        idle_in();
        dis_wr = 1'b1; dis_wdata = 32'h20;
        step();
        idle_in();
        chk("R4 drain flag", dis_stat, 16'h0020);
        for (int k = 0; k < 14; k++) begin
            txn_done = 16'h0020;
            step();
        end
        idle_in();
        chk("R4 still draining", act_stat, 16'h0020);
        txn_done = 16'h0020;
        step();
        idle_in();
        chk("R4 drained act", act_stat, 16'h0000);
        chk("R4 drained dis", dis_stat, 16'h0000);

        // R9: falling control active bit on running channel 6
        en_wr = 1'b1; en_wdata = 32'h40;
        step();
        idle_in();
        chk("R9 running", act_stat, 16'h0040);
        ctl_act = 16'hFFBF;
        step();
        chk("R9 stopped", act_stat, 16'h0000);
        chk("R9 no flag", dis_stat, 16'h0000);
        ctl_act = 16'hFFFF;

        // R5: request to idle channel 7 is not replayed after enable
        req = 16'h0080;
        #1;
        chk("R5 idle drop", issue, 16'h0000);
        step();
        idle_in();
        en_wr = 1'b1; en_wdata = 32'h80;
        step();
        idle_in();
        #1;
        chk("R5 no replay", issue, 16'h0000);

        // R1: reset while running
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 mid reset act", act_stat, 16'h0000);
        chk("R1 mid reset dis", dis_stat, 16'h0000);

        finish_run();
    end
endmodule